// File: doc/BRIEF.md
# Link-Layer Transmit Register Sequencer

This block moves one outgoing packet at a time from a host-side word stream into the register interface of an external serial-bus link controller. The host presents a fixed number of header words followed by a payload of one or more 32-bit words, with a last flag on the final payload word. The header words go into the controller's control registers. Each payload word goes to one of three data registers, and its position in the packet decides which one. Every register write is a request that stays up until the controller acknowledges it. The acknowledge can arrive in the first cycle of the request or several cycles later.

The host stream is a valid/ready interface. It stalls while a write is outstanding. Writes go back to back without extra wait states when each acknowledge comes at once. After the write that closes the packet, no further word is accepted until the controller's ready line is seen high again. A watchdog ends any write whose acknowledge does not come within a fixed window. It flags an error and returns the sequencer to the start of a packet.

Top module: `lnk_tx_seq`

## Requirements
- R1: The first HDR_WORDS accepted words of a packet are written to control addresses CTRL_BASE+0, CTRL_BASE+1, ... in arrival order (defaults: HDR_WORDS=2, CTRL_BASE=0).
- R2: In a packet with two or more payload words, the first payload word is written to the start address ADDR_START (default 4).
- R3: Payload words that are neither first nor last are written to the continuation address ADDR_CONT (default 5).
- R4: The payload word flagged last is written to the end address ADDR_END (default 6). A one-word payload goes straight to ADDR_END, with no write to ADDR_START.
- R5: A write request holds its address and data unchanged until reg_ack_i is high while reg_req_o is high. That acknowledge may come in the first request cycle or after any latency up to 9 cycles, and no error results.
- R6: When every acknowledge arrives in the first request cycle and the host never pauses, a packet of N words is accepted in N consecutive cycles, one write per cycle.
- R7: in_ready_o is low in any cycle where a write is pending and reg_ack_i is low.
- R8: After the end-address write is acknowledged, in_ready_o stays low until lnk_ready_i has been sampled high in a later cycle.
- R9: If a write sees no acknowledge for 16 cycles, err_o pulses for exactly one cycle and reg_req_o drops in the same cycle. The write is discarded, and the next accepted word is treated as header word 0.
- R10: After reset, reg_req_o and err_o are low and in_ready_o is high.
- R11: reg_wdata_o carries the accepted in_data_i word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Link clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Host word valid |
| in_data_i | input | 32 | Host word |
| in_last_i | input | 1 | Marks final payload word of a packet |
| in_ready_o | output | 1 | Block can accept a word this cycle |
| reg_req_o | output | 1 | Register write request, held until acknowledged |
| reg_addr_o | output | 4 | Register address of the pending write |
| reg_wdata_o | output | 32 | Data of the pending write |
| reg_ack_i | input | 1 | Write acknowledge from the link controller |
| lnk_ready_i | input | 1 | Link controller ready for a new packet |
| err_o | output | 1 | One-cycle pulse on acknowledge timeout |

## Verification
Random packets with payloads of one to eight words run against a link model that gives random acknowledge latencies from 1 to 9 cycles, random host gaps and random ready drop-outs. Every logged register write is compared with an address computed from its position in the packet. One-word and two-word payloads separate the direct-to-end path and the start-then-end path from the middle-word path. A burst with first-cycle acknowledges and no host gaps must finish without a single stall, which exposes any added wait state. A link that never acknowledges checks the 16-cycle timeout and the clean restart at header word 0 that follows it.

// File: rtl/lnk_tx_pkg.sv
package lnk_tx_pkg;
  typedef enum logic [1:0] {POS_HDR, POS_FIRST, POS_MID} pos_e;
  typedef enum logic {ST_RUN, ST_HOLD} st_e;
endpackage

// File: rtl/lnk_tx_addr_sel.sv
module lnk_tx_addr_sel
  import lnk_tx_pkg::*;
#(
  parameter int unsigned HDR_WORDS = 2,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned HCNT_W    = 1,
  parameter logic [ADDR_W-1:0] CTRL_BASE  = 'd0,
  parameter logic [ADDR_W-1:0] ADDR_START = 'd4,
  parameter logic [ADDR_W-1:0] ADDR_CONT  = 'd5,
  parameter logic [ADDR_W-1:0] ADDR_END   = 'd6
) (
  input  pos_e              pos_i,
  input  logic [HCNT_W-1:0] hcnt_i,
  input  logic              last_i,
  output logic [ADDR_W-1:0] addr_o,
  output pos_e              pos_nxt_o,
  output logic [HCNT_W-1:0] hcnt_nxt_o,
  output logic              is_end_o
);
  always_comb begin
    addr_o     = CTRL_BASE;
    pos_nxt_o  = pos_i;
    hcnt_nxt_o = hcnt_i;
    is_end_o   = 1'b0;
    unique case (pos_i)
      POS_HDR: begin
        addr_o = CTRL_BASE + ADDR_W'(hcnt_i);
        if (hcnt_i == HCNT_W'(HDR_WORDS - 1)) begin
          pos_nxt_o  = POS_FIRST;
          hcnt_nxt_o = '0;
        end else begin
          hcnt_nxt_o = hcnt_i + 1'b1;
        end
      end
      POS_FIRST: begin
        // single-word payload skips the start register
        addr_o    = last_i ? ADDR_END : ADDR_START;
        is_end_o  = last_i;
        pos_nxt_o = last_i ? POS_HDR : POS_MID;
      end
      POS_MID: begin
        addr_o    = last_i ? ADDR_END : ADDR_CONT;
        is_end_o  = last_i;
        pos_nxt_o = last_i ? POS_HDR : POS_MID;
      end
      default: pos_nxt_o = POS_HDR;
    endcase
  end
endmodule

// File: rtl/lnk_tx_wdog.sv
module lnk_tx_wdog #(
  parameter int unsigned TIMEOUT = 16,
  localparam int unsigned CNT_W  = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wait_i,
  output logic expire_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!wait_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = wait_i && (cnt_q == CNT_W'(TIMEOUT - 1));
endmodule

// File: rtl/lnk_tx_seq.sv
module lnk_tx_seq
  import lnk_tx_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned HDR_WORDS = 2,
  parameter int unsigned TIMEOUT   = 16,
  parameter logic [ADDR_W-1:0] CTRL_BASE  = 'd0,
  parameter logic [ADDR_W-1:0] ADDR_START = 'd4,
  parameter logic [ADDR_W-1:0] ADDR_CONT  = 'd5,
  parameter logic [ADDR_W-1:0] ADDR_END   = 'd6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_last_i,
  output logic              in_ready_o,
  output logic              reg_req_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  input  logic              reg_ack_i,
  input  logic              lnk_ready_i,
  output logic              err_o
);
  localparam int unsigned HCNT_W = (HDR_WORDS > 1) ? $clog2(HDR_WORDS) : 1;

  st_e               st_q;
  pos_e              pos_q, pos_nxt;
  logic [HCNT_W-1:0] hcnt_q, hcnt_nxt;
  logic              req_q, end_q, err_q;
  logic [ADDR_W-1:0] addr_q, sel_addr;
  logic [DATA_W-1:0] data_q;
  logic              sel_end, accept, done, expire;

  lnk_tx_addr_sel #(
    .HDR_WORDS(HDR_WORDS), .ADDR_W(ADDR_W), .HCNT_W(HCNT_W),
    .CTRL_BASE(CTRL_BASE), .ADDR_START(ADDR_START),
    .ADDR_CONT(ADDR_CONT), .ADDR_END(ADDR_END)
  ) u_sel (
    .pos_i(pos_q), .hcnt_i(hcnt_q), .last_i(in_last_i),
    .addr_o(sel_addr), .pos_nxt_o(pos_nxt), .hcnt_nxt_o(hcnt_nxt),
    .is_end_o(sel_end)
  );

  lnk_tx_wdog #(.TIMEOUT(TIMEOUT)) u_wdog (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wait_i(req_q && !reg_ack_i), .expire_o(expire)
  );

  // accept in the ack cycle itself so first-cycle acks add no wait state
  assign in_ready_o = (st_q == ST_RUN) && (!req_q || (reg_ack_i && !end_q));
  assign accept     = in_valid_i && in_ready_o;
  assign done       = req_q && reg_ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_RUN;
      pos_q  <= POS_HDR;
      hcnt_q <= '0;
      req_q  <= 1'b0;
      end_q  <= 1'b0;
      err_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      err_q <= expire;
      if (expire) begin
        req_q  <= 1'b0;
        end_q  <= 1'b0;
        pos_q  <= POS_HDR;
        hcnt_q <= '0;
        st_q   <= ST_RUN;
      end else begin
        if (accept) begin
          req_q  <= 1'b1;
          end_q  <= sel_end;
          addr_q <= sel_addr;
          data_q <= in_data_i;
          pos_q  <= pos_nxt;
          hcnt_q <= hcnt_nxt;
        end else if (done) begin
          req_q <= 1'b0;
          end_q <= 1'b0;
        end
        if (done && end_q)                        st_q <= ST_HOLD;
        else if (st_q == ST_HOLD && lnk_ready_i)  st_q <= ST_RUN;
      end
    end
  end

  assign reg_req_o   = req_q;
  assign reg_addr_o  = addr_q;
  assign reg_wdata_o = data_q;
  assign err_o       = err_q;
endmodule

// File: rtl/lnk_tx_seq_chk.sv
module lnk_tx_seq_chk #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned HDR_WORDS = 2,
  parameter logic [ADDR_W-1:0] CTRL_BASE  = 'd0,
  parameter logic [ADDR_W-1:0] ADDR_START = 'd4,
  parameter logic [ADDR_W-1:0] ADDR_CONT  = 'd5,
  parameter logic [ADDR_W-1:0] ADDR_END   = 'd6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_ready_o,
  input logic              reg_req_o,
  input logic [ADDR_W-1:0] reg_addr_o,
  input logic [DATA_W-1:0] reg_wdata_o,
  input logic              reg_ack_i,
  input logic              err_o
);
  a_r5_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o && !reg_ack_i |=> err_o ||
      (reg_req_o && $stable(reg_addr_o) && $stable(reg_wdata_o)));

  a_r7_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o && !reg_ack_i |-> !in_ready_o);

  a_r8_end_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o && reg_ack_i && reg_addr_o == ADDR_END |=> !in_ready_o && !reg_req_o);

  a_r9_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);

  a_r9_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !reg_req_o);

  a_r1_addr_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o |-> (reg_addr_o >= CTRL_BASE &&
                   reg_addr_o < CTRL_BASE + ADDR_W'(HDR_WORDS)) ||
                  reg_addr_o == ADDR_START || reg_addr_o == ADDR_CONT ||
                  reg_addr_o == ADDR_END);
endmodule

bind lnk_tx_seq lnk_tx_seq_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .HDR_WORDS(HDR_WORDS),
  .CTRL_BASE(CTRL_BASE), .ADDR_START(ADDR_START),
  .ADDR_CONT(ADDR_CONT), .ADDR_END(ADDR_END)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_ready_o(in_ready_o),
  .reg_req_o(reg_req_o), .reg_addr_o(reg_addr_o), .reg_wdata_o(reg_wdata_o),
  .reg_ack_i(reg_ack_i), .err_o(err_o)
);

// File: tb/sim_lnk_tx_seq.sv
`timescale 1ns/1ps
module sim_lnk_tx_seq;
  localparam int H = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_last = 1'b0;
  logic        in_ready;
  logic        req;
  logic [3:0]  addr;
  logic [31:0] wdata;
  logic        ack = 1'b0;
  logic        lnk_ready = 1'b1;
  logic        err;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  lnk_tx_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_data_i(in_data),
    .in_last_i(in_last), .in_ready_o(in_ready), .reg_req_o(req),
    .reg_addr_o(addr), .reg_wdata_o(wdata), .reg_ack_i(ack),
    .lnk_ready_i(lnk_ready), .err_o(err)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  function automatic int exp_addr(input int i, input int n);
    int j;
    if (i < H) return i;
    j = i - H;
    if (j == n - 1) return 6;
    if (j == 0) return 4;
    return 5;
  endfunction

  function automatic string req_of(input int a);
    if (a < H)  return "R1";
    if (a == 4) return "R2";
    if (a == 5) return "R3";
    return "R4";
  endfunction

  // link model state
  int q_addr[$];
  int q_data[$];
  bit never_ack = 0;
  bit fast_ack  = 0;
  int lat = 1;
  int wcnt = 0;
  int busy = 0;
  int streak = 0;
  int err_seen = 0;
  int r7_viol = 0;
  int r8_viol = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      ack = 1'b0; wcnt = 0; lnk_ready = 1'b1; busy = 0;
    end else begin
      if (err) err_seen++;
      if (busy > 0) begin
        busy--;
        if (busy == 0) lnk_ready = 1'b1;
      end
      if (req) begin
        if (never_ack) streak++;
        wcnt++;
        ack = !never_ack && (wcnt >= lat);
        if (ack) begin
          if (q_addr.size() == 0) begin
            chk(0, "R1", "unexpected write addr", addr, -1);
          end else begin
            int ea, ed;
            ea = q_addr.pop_front();
            ed = q_data.pop_front();
            chk(addr == ea, req_of(ea), "write address", addr, ea);
            chk(wdata == ed, "R11", "write data", wdata, ed);
          end
          wcnt = 0;
          lat = fast_ack ? 1 : 1 + int'($urandom % 9);
          if (addr == 4'd6) begin
            lnk_ready = 1'b0;
            busy = 1 + int'($urandom % 6);
          end
        end
      end else begin
        ack = 1'b0; wcnt = 0;
      end
    end
  end

  // returns number of stalled cycles
  task automatic send_pkt(input int n, input int gap_pct, output int stalls);
    stalls = 0;
    for (int i = 0; i < H + n; i++) begin
      bit acc;
      logic [31:0] d;
      d = $urandom;
      acc = 0;
      while (!acc) begin
        @(negedge clk);
        #0.5;
        in_valid = (int'($urandom % 100) >= gap_pct);
        in_data  = d;
        in_last  = (i == H + n - 1);
        #1;
        if (req && !ack && in_ready) r7_viol++;
        if (!lnk_ready && in_ready) r8_viol++;
        acc = in_valid && in_ready;
        if (in_valid && !acc) stalls++;
      end
      q_addr.push_back(exp_addr(i, n));
      q_data.push_back(int'(d));
    end
    @(negedge clk);
    #0.5;
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic drain();
    repeat (30) @(negedge clk);
  endtask

  initial begin
    int st;
    void'($urandom(32'd1394));
    repeat (3) @(negedge clk);
    #1;
    // R10 reset state
    chk(req == 1'b0, "R10", "reg_req_o in reset", req, 0);
    chk(err == 1'b0, "R10", "err_o in reset", err, 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(in_ready == 1'b1, "R10", "in_ready_o after reset", in_ready, 1);

    // R4 single-word payload, R2 two-word payload
    send_pkt(1, 0, st);
    drain();
    send_pkt(2, 0, st);
    drain();

    // R6 zero wait states with first-cycle acks
    fast_ack = 1; lat = 1;
    send_pkt(5, 0, st);
    chk(st == 0, "R6", "stalled cycles in burst", st, 0);
    drain();
    fast_ack = 0;

    // R1-style position checks and R5 latency spread under random traffic
    for (int p = 0; p < 40; p++) begin
      send_pkt(1 + int'($urandom % 8), 30, st);
    end
    drain();
    chk(q_addr.size() == 0, "R5", "writes left unacknowledged", q_addr.size(), 0);
    chk(err_seen == 0, "R5", "timeouts with latency up to 9", err_seen, 0);
    chk(r7_viol == 0, "R7", "ready while write pending", r7_viol, 0);
    chk(r8_viol == 0, "R8", "ready while link not ready", r8_viol, 0);

    // R9 timeout
    never_ack = 1; streak = 0;
    @(negedge clk); #0.5;
    in_valid = 1'b1; in_data = 32'hdead_beef; in_last = 1'b0;
    #1;
    chk(in_ready == 1'b1, "R9", "ready before stuck write", in_ready, 1);
    @(negedge clk); #0.5;
    in_valid = 1'b0;
    repeat (25) @(negedge clk);
    #1;
    chk(streak == 16, "R9", "request cycles before timeout", streak, 16);
    chk(err_seen == 1, "R9", "err_o pulse count", err_seen, 1);
    chk(req == 1'b0, "R9", "request dropped after timeout", req, 0);
    chk(in_ready == 1'b1, "R9", "ready after timeout", in_ready, 1);
    never_ack = 0;
    q_addr.delete(); q_data.delete();
    // restart at header word 0
    send_pkt(3, 0, st);
    drain();
    chk(q_addr.size() == 0, "R9", "writes pending after restart", q_addr.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule